// File: doc/BRIEF.md
# Pin-Change and External Interrupt Unit

This unit watches a bank of general-purpose input pins and one dedicated external interrupt line, and turns activity on them into interrupt requests for a processor core. The pins form two groups, each with its own enable bit. A rising or falling transition on any pin in an enabled group sets one shared pin-change flag. A pin whose alternate function is active is kept out of that flag. The external line has four selectable sense modes. In the edge modes it sets its own flag. In level mode the line drives the request directly and its flag is held at zero.

Both flags live in one 8-bit flag register. Software reads it and clears either bit by writing a one to it. The core clears a flag with an acknowledge pulse that carries the vector number it is servicing. A request goes out only while the global interrupt enable is set. The unit then reports vector 1 for the external line or vector 2 for pin change, and the external line wins when both are pending. Every input is synchronized by two flip-flops before it is examined.

Top module: `pcx_irq_unit`

## Requirements
- R1: Pin indices 3..0 of `pin_i` form the low group, enabled by `grp_en_i[0]`. Indices 10..4 form the high group, enabled by `grp_en_i[1]`. A rising or falling change on an enabled pin sets `flags_o[5]` three clock edges after the input changes.
- R2: A change on a pin whose group enable is clear never sets `flags_o[5]`.
- R3: A change on a pin whose `alt_i` bit is one never sets `flags_o[5]`.
- R4: `flags_o` is all zeros after reset. Bit 5 holds the pin-change flag and bit 6 holds the external flag. Bits 7 and 4..0 always read zero.
- R5: A write (`wr_en_i`) clears bit 5 or bit 6 of the flag register when the matching bit of `wr_data_i` is one. A zero in `wr_data_i` leaves the flag unchanged. The effect shows after one edge.
- R6: An acknowledge pulse (`ack_i`) clears the external flag when `ack_vec_i` is 1 and the pin-change flag when `ack_vec_i` is 2. The effect shows after one edge.
- R7: When a set event and a clear by write or acknowledge hit a flag on the same edge, the flag ends up set.
- R8: `sense_i` selects the external line mode: 00 low level, 01 any edge, 10 falling edge, 11 rising edge. In the three edge modes a matching edge on `ext_i` sets `flags_o[6]` three edges after it, and any other edge does not set it.
- R9: In low-level mode `flags_o[6]` is forced to zero on the next edge. The external request follows the synchronized line, asserting two edges after `ext_i` goes low and dropping two edges after it goes high.
- R10: `irq_o` is asserted only while `gie_i` is one. The external request also needs `ext_en_i`. The pin-change request needs at least one group enable and a set pin-change flag.
- R11: `irq_vec_o` is 1 for the external request, 2 for the pin-change request and 0 when there is no request. The external request wins when both are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 11 | Monitored pins, asynchronous |
| alt_i | input | 11 | Per-pin alternate-function active, masks that pin |
| grp_en_i | input | 2 | Group enables: bit 1 high group, bit 0 low group |
| ext_i | input | 1 | External interrupt line, asynchronous |
| sense_i | input | 2 | External line sense mode |
| ext_en_i | input | 1 | External interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Write strobe for the flag register |
| wr_data_i | input | 8 | Write data, a one clears that flag |
| ack_i | input | 1 | Interrupt serviced pulse |
| ack_vec_i | input | 2 | Vector number being serviced |
| flags_o | output | 8 | Flag register read value |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 2 | Vector number of the winning request |

## Verification
A pin or edge-mode line event reaches `flags_o` and the request three edges after the input moves: two synchronizer stages, then the flag register. A low-level request appears after two edges, because it follows the second synchronizer stage directly. Writes and acknowledges act after one edge, and a change of `gie_i` or `ext_en_i` shows in the same cycle. The driver applies each stimulus just after a rising edge and queues the expected value against that exact cycle count. It also queues the value one cycle early where the latency itself is under test. The monitor compares at the falling edge, so every value is checked in the cycle it becomes due and not merely at some later point.

// File: rtl/pcx_irq_pkg.sv
package pcx_irq_pkg;

    localparam int FLAG_W  = 8;
    localparam int PC_BIT  = 5;
    localparam int EXT_BIT = 6;
    localparam int VEC_W   = 2;

    localparam logic [VEC_W-1:0] VEC_NONE = 2'd0;
    localparam logic [VEC_W-1:0] VEC_EXT  = 2'd1;
    localparam logic [VEC_W-1:0] VEC_PC   = 2'd2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic pc_flag;
        logic ext_flag;
    } flag_state_t;

endpackage

// File: rtl/pcx_sync.sv
// Two-stage synchronizer for a vector of asynchronous inputs.
module pcx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = async_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/pcx_edge_det.sv
// Compares each synchronized bit against its previous sample.
module pcx_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q, prev_d;

    always_comb begin
        prev_d = cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = cur_i & ~prev_q;
    assign fall_o = ~cur_i & prev_q;
endmodule

// File: rtl/pcx_ext_sense.sv
// Turns the synchronized external line into an event or a level request.
module pcx_ext_sense
    import pcx_irq_pkg::*;
(
    input  sense_e mode_i,
    input  logic   level_i,
    input  logic   rise_i,
    input  logic   fall_i,
    output logic   evt_o,
    output logic   lvl_req_o
);
    always_comb begin
        evt_o     = 1'b0;
        lvl_req_o = 1'b0;
        unique case (mode_i)
            SENSE_LOW:  lvl_req_o = ~level_i;
            SENSE_ANY:  evt_o     = rise_i | fall_i;
            SENSE_FALL: evt_o     = fall_i;
            SENSE_RISE: evt_o     = rise_i;
            default:    evt_o     = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcx_irq_unit.sv
module pcx_irq_unit
    import pcx_irq_pkg::*;
#(
    parameter int LO_W = 4,
    parameter int HI_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LO_W+HI_W-1:0]    pin_i,
    input  logic [LO_W+HI_W-1:0]    alt_i,
    input  logic [1:0]              grp_en_i,
    input  logic                    ext_i,
    input  logic [1:0]              sense_i,
    input  logic                    ext_en_i,
    input  logic                    gie_i,
    input  logic                    wr_en_i,
    input  logic [FLAG_W-1:0]       wr_data_i,
    input  logic                    ack_i,
    input  logic [VEC_W-1:0]        ack_vec_i,
    output logic [FLAG_W-1:0]       flags_o,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        irq_vec_o
);
    localparam int NPIN = LO_W + HI_W;
    localparam int SW   = NPIN + 1;   // pins plus external line

    sense_e            mode;
    logic [SW-1:0]     sync_v, rise_v, fall_v;
    logic [NPIN-1:0]   pin_chg, grp_mask;
    logic              ext_level, ext_evt, ext_lvl_req;
    logic              pc_set, ext_set, pc_clr, ext_clr;
    logic              pc_req, ext_req;
    flag_state_t       st_q, st_d;
    logic              unused_wr;

    assign mode      = sense_e'(sense_i);
    assign unused_wr = ^{wr_data_i[FLAG_W-1:EXT_BIT+1], wr_data_i[PC_BIT-1:0]};

    pcx_sync #(.W(SW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_i, pin_i}),
        .sync_o  (sync_v)
    );

    pcx_edge_det #(.W(SW)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (sync_v),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    assign ext_level = sync_v[NPIN];

    pcx_ext_sense u_sense (
        .mode_i    (mode),
        .level_i   (ext_level),
        .rise_i    (rise_v[NPIN]),
        .fall_i    (fall_v[NPIN]),
        .evt_o     (ext_evt),
        .lvl_req_o (ext_lvl_req)
    );

    // Per-pin group enable: low indices follow bit 0, the rest bit 1.
    for (genvar i = 0; i < NPIN; i++) begin : g_mask
        if (i < LO_W) begin : g_lo
            assign grp_mask[i] = grp_en_i[0];
        end else begin : g_hi
            assign grp_mask[i] = grp_en_i[1];
        end
    end

    assign pin_chg = rise_v[NPIN-1:0] | fall_v[NPIN-1:0];

    always_comb begin
        st_d    = st_q;
        pc_set  = |(pin_chg & grp_mask & ~alt_i);
        ext_set = ext_evt;
        pc_clr  = (wr_en_i & wr_data_i[PC_BIT])  | (ack_i & (ack_vec_i == VEC_PC));
        ext_clr = (wr_en_i & wr_data_i[EXT_BIT]) | (ack_i & (ack_vec_i == VEC_EXT));

        // A set on the same edge as a clear wins.
        st_d.pc_flag = pc_set | (st_q.pc_flag & ~pc_clr);
        if (mode == SENSE_LOW) st_d.ext_flag = 1'b0;
        else                   st_d.ext_flag = ext_set | (st_q.ext_flag & ~ext_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags_o          = '0;
        flags_o[PC_BIT]  = st_q.pc_flag;
        flags_o[EXT_BIT] = st_q.ext_flag;

        pc_req  = gie_i & (|grp_en_i) & st_q.pc_flag;
        ext_req = gie_i & ext_en_i &
                  ((mode == SENSE_LOW) ? ext_lvl_req : st_q.ext_flag);

        irq_o = ext_req | pc_req;
        if (ext_req)     irq_vec_o = VEC_EXT;
        else if (pc_req) irq_vec_o = VEC_PC;
        else             irq_vec_o = VEC_NONE;
    end
endmodule

// File: rtl/pcx_irq_chk.sv
module pcx_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] flags_o,
    input logic       irq_o,
    input logic [1:0] irq_vec_o,
    input logic       gie_i,
    input logic       ext_en_i,
    input logic [1:0] sense_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       ack_i,
    input logic [1:0] ack_vec_i,
    input logic       pc_set,
    input logic       ext_set
);
    p_w1c_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[5] && !pc_set) |=> !flags_o[5]);

    p_hold_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[5] && !(wr_en_i && wr_data_i[5]) && !(ack_i && ack_vec_i == 2'd2))
            |=> flags_o[5]);

    p_ack_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_vec_i == 2'd1 && !ext_set) |=> !flags_o[6]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_set |=> flags_o[5]);

    p_ext_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_set && sense_i != 2'b00) |=> flags_o[6]);

    p_level_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == 2'b00) |=> !flags_o[6]);

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i);

    p_vec_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec_o != 2'd0));

    p_vec_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_vec_o == 2'd0));

    p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_i && ext_en_i && sense_i != 2'b00 && flags_o[6]) |-> (irq_vec_o == 2'd1));
endmodule

bind pcx_irq_unit pcx_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_o   (flags_o),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o),
    .gie_i     (gie_i),
    .ext_en_i  (ext_en_i),
    .sense_i   (sense_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ack_i     (ack_i),
    .ack_vec_i (ack_vec_i),
    .pc_set    (pc_set),
    .ext_set   (ext_set)
);

// File: tb/pcx_irq_unit_tb.sv
module pcx_irq_unit_tb;
    localparam int NPIN = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_i = '0;
    logic [NPIN-1:0] alt_i = '0;
    logic [1:0]      grp_en_i = 2'b00;
    logic            ext_i = 1'b1;
    logic [1:0]      sense_i = 2'b10;
    logic            ext_en_i = 1'b0;
    logic            gie_i = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [7:0]      wr_data_i = '0;
    logic            ack_i = 1'b0;
    logic [1:0]      ack_vec_i = '0;
    logic [7:0]      flags_o;
    logic            irq_o;
    logic [1:0]      irq_vec_o;

    pcx_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .alt_i(alt_i),
        .grp_en_i(grp_en_i), .ext_i(ext_i), .sense_i(sense_i),
        .ext_en_i(ext_en_i), .gie_i(gie_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .ack_i(ack_i), .ack_vec_i(ack_vec_i),
        .flags_o(flags_o), .irq_o(irq_o), .irq_vec_o(irq_vec_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int         cyc;
        logic [7:0] flags;
        logic       irq;
        logic [1:0] vec;
        int         req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int dly, input logic [7:0] f, input logic i,
                             input logic [1:0] v, input int req);
        exp_t e;
        e.cyc = cyc + dly; e.flags = f; e.irq = i; e.vec = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_drain();
        while (q.size() > 0) tick();
        tick();
    endtask

    // Monitor: compares each queued item in its due cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (e.cyc != cyc || flags_o !== e.flags || irq_o !== e.irq ||
                    irq_vec_o !== e.vec) begin
                    bad++;
                    $display("FAIL R%0d cyc=%0d due=%0d: flags=%h irq=%b vec=%0d expected flags=%h irq=%b vec=%0d",
                             e.req, cyc, e.cyc, flags_o, irq_o, irq_vec_o, e.flags, e.irq, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R4: reset state
        total++;
        if (flags_o !== 8'h00 || irq_o !== 1'b0 || irq_vec_o !== 2'd0) begin
            bad++;
            $display("FAIL R4 reset: flags=%h irq=%b vec=%0d expected flags=00 irq=0 vec=0",
                     flags_o, irq_o, irq_vec_o);
        end
        rst_n = 1'b1;
        repeat (4) tick();

        // R1, R10, R11: low group change, latency three edges
        grp_en_i = 2'b01; gie_i = 1'b1;
        tick();
        pin_i[0] = ~pin_i[0];
        expect_at(2, 8'h00, 1'b0, 2'd0, 1);
        expect_at(3, 8'h20, 1'b1, 2'd2, 1);
        wait_drain();

        // R5: writing zeros has no effect, writing one clears
        wr_en_i = 1'b1; wr_data_i = 8'hDF;
        expect_at(1, 8'h20, 1'b1, 2'd2, 5);
        tick(); wr_en_i = 1'b0;
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h20;
        expect_at(1, 8'h00, 1'b0, 2'd0, 5);
        tick(); wr_en_i = 1'b0;
        wait_drain();

        // R2: high group disabled
        pin_i[6] = ~pin_i[6];
        expect_at(3, 8'h00, 1'b0, 2'd0, 2);
        expect_at(5, 8'h00, 1'b0, 2'd0, 2);
        wait_drain();

        // R3: alternate-function pin masked
        grp_en_i = 2'b11; alt_i[7] = 1'b1;
        repeat (3) tick();
        pin_i[7] = ~pin_i[7];
        expect_at(3, 8'h00, 1'b0, 2'd0, 3);
        expect_at(5, 8'h00, 1'b0, 2'd0, 3);
        wait_drain();

        // R1: high group rising edge
        pin_i[8] = 1'b1;
        expect_at(3, 8'h20, 1'b1, 2'd2, 1);
        wait_drain();

        // R6: acknowledge with vector 2 clears pin-change flag
        ack_i = 1'b1; ack_vec_i = 2'd2;
        expect_at(1, 8'h00, 1'b0, 2'd0, 6);
        tick(); ack_i = 1'b0;
        wait_drain();

        // R1: high group falling edge
        pin_i[8] = 1'b0;
        expect_at(3, 8'h20, 1'b1, 2'd2, 1);
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h20;
        tick(); wr_en_i = 1'b0;
        wait_drain();

        // R7: set and write-one on the same edge
        pin_i[0] = ~pin_i[0];
        tick(); tick();
        wr_en_i = 1'b1; wr_data_i = 8'h20;
        expect_at(1, 8'h20, 1'b1, 2'd2, 7);
        tick(); wr_en_i = 1'b0;
        expect_at(1, 8'h20, 1'b1, 2'd2, 7);
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h20;
        tick(); wr_en_i = 1'b0;
        wait_drain();

        // R8, R11: falling edge on external line plus pin change, priority
        ext_en_i = 1'b1;
        tick();
        ext_i = 1'b0; pin_i[1] = ~pin_i[1];
        expect_at(3, 8'h60, 1'b1, 2'd1, 11);
        wait_drain();

        // R6: acknowledge with vector 1 clears external flag
        ack_i = 1'b1; ack_vec_i = 2'd1;
        expect_at(1, 8'h20, 1'b1, 2'd2, 6);
        tick(); ack_i = 1'b0;
        wait_drain();

        // R10: global enable gates request, flags remain
        gie_i = 1'b0;
        expect_at(0, 8'h20, 1'b0, 2'd0, 10);
        wait_drain();
        gie_i = 1'b1;
        wr_en_i = 1'b1; wr_data_i = 8'h20;
        expect_at(1, 8'h00, 1'b0, 2'd0, 5);
        tick(); wr_en_i = 1'b0;
        wait_drain();

        // R8: rising mode
        sense_i = 2'b11;
        tick();
        ext_i = 1'b1;
        expect_at(3, 8'h40, 1'b1, 2'd1, 8);
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h40;
        expect_at(1, 8'h00, 1'b0, 2'd0, 5);
        tick(); wr_en_i = 1'b0;
        wait_drain();
        ext_i = 1'b0;
        expect_at(3, 8'h00, 1'b0, 2'd0, 8);
        expect_at(5, 8'h00, 1'b0, 2'd0, 8);
        wait_drain();

        // R8: any-edge mode, both directions
        sense_i = 2'b01;
        tick();
        ext_i = 1'b1;
        expect_at(3, 8'h40, 1'b1, 2'd1, 8);
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h40;
        tick(); wr_en_i = 1'b0;
        wait_drain();
        ext_i = 1'b0;
        expect_at(3, 8'h40, 1'b1, 2'd1, 8);
        wait_drain();
        wr_en_i = 1'b1; wr_data_i = 8'h40;
        tick(); wr_en_i = 1'b0;
        wait_drain();

        // R10: external enable off
        ext_en_i = 1'b0;
        tick();
        ext_i = 1'b1;
        expect_at(3, 8'h40, 1'b0, 2'd0, 10);
        wait_drain();

        // R9: level mode clears pending flag, request follows line
        sense_i = 2'b00;
        expect_at(1, 8'h00, 1'b0, 2'd0, 9);
        wait_drain();
        ext_en_i = 1'b1;
        tick();
        ext_i = 1'b0;
        expect_at(1, 8'h00, 1'b0, 2'd0, 9);
        expect_at(2, 8'h00, 1'b1, 2'd1, 9);
        wait_drain();
        ext_i = 1'b1;
        expect_at(1, 8'h00, 1'b1, 2'd1, 9);
        expect_at(2, 8'h00, 1'b0, 2'd0, 9);
        wait_drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule